// File: doc/BRIEF.md
# Gated Event Timer with Prescaled and Reload Modes

This block is a small timer/counter built around a count register made of two bytes, a low byte and a high byte. It has two counting modes. In prescaled mode, the bottom five bits of the low byte act as a divide-by-32 stage in front of an 8-bit counter held in the high byte, which gives a 13-bit count. In reload mode, only the low byte counts. When it wraps, it takes its new start value from the high byte, so it repeats a fixed period without software help.

Each count step comes from one of two sources. In timer mode the block counts every clock. In counter mode it counts falling edges of an external event pin, which first passes through a synchronizer. Counting is allowed only while the run input is high. When gating is selected, the external gate input must also be high. Every wrap sets a sticky overflow flag, and the flag clears when the interrupt is acknowledged. An optional waveform output inverts on each wrap, which turns the timer into a programmable clock source. Software can write either count byte and the flag at any time.

Top module: `evtmr_top`

## Requirements
- R1: While reset is active, both count bytes read 0, the overflow flag reads 0 and the waveform output reads 0.
- R2: Prescaled mode (`mode_sel`=0). Each step increments bits 4:0 of the low byte. When those bits step from 31, they return to 0 and the high byte increments. Bits 7:5 of the low byte never change in this mode.
- R3: Prescaled mode wrap. A step taken with the high byte at 0xFF and low bits 4:0 at 31 sets the high byte and low bits 4:0 to 0 and sets the overflow flag.
- R4: Reload mode (`mode_sel`=1). Each step increments the low byte. A step taken at low byte 0xFF instead loads the low byte from the high byte and sets the overflow flag. Counting never changes the high byte in this mode.
- R5: A one-cycle `int_ack` clears the overflow flag on the next clock. If an overflow happens in the same cycle, the overflow wins and the flag stays set.
- R6: A step is taken only when `run_en` is 1 and either `gate_en` is 0 or `gate_in` is 1. Otherwise the count holds.
- R7: With `evt_sel`=0, the block steps on every enabled clock. With `evt_sel`=1, `evt_pin` passes through two synchronizing flops, and one step is taken for each 1-to-0 transition seen at the synchronizer output. That step lands on the third rising clock edge after the falling pin value is first sampled. A pin held at one level causes no steps.
- R8: A write strobe (`lo_wr`, `hi_wr`, `flag_wr`) loads its data on the next clock. The written value replaces whatever counting would have produced for that byte or that flag in the same cycle.
- R9: `tgl_out` inverts on every overflow while `tgl_en` is 1. While `tgl_en` is 0 it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Run control |
| gate_en | input | 1 | Makes counting also depend on gate_in |
| gate_in | input | 1 | External gate level |
| evt_sel | input | 1 | 0 = count clocks, 1 = count evt_pin falling edges |
| mode_sel | input | 1 | 0 = prescaled 13-bit, 1 = 8-bit reload |
| evt_pin | input | 1 | Asynchronous external event input |
| lo_wr | input | 1 | Low byte write strobe |
| lo_wdata | input | 8 | Low byte write data |
| hi_wr | input | 1 | High byte write strobe |
| hi_wdata | input | 8 | High byte write data |
| flag_wr | input | 1 | Overflow flag write strobe |
| flag_wdata | input | 1 | Overflow flag write value |
| int_ack | input | 1 | Interrupt acknowledge, clears the flag |
| tgl_en | input | 1 | Enables the waveform output to invert on overflow |
| cnt_lo | output | 8 | Low count byte |
| cnt_hi | output | 8 | High count byte |
| ovf_flag | output | 1 | Sticky overflow flag |
| tgl_out | output | 1 | Waveform output |

## Verification
The bench builds the block with its defaults: 8-bit count bytes, a 5-bit prescaler, a two-flop synchronizer and the waveform output present. With these values a 13-bit wrap takes only a few steps once software preloads the bytes near their top. The divide-by-32 carry into the high byte is therefore reached in tens of cycles. A reload period of two steps makes the waveform output invert at a rate that is easy to follow. Preloading also lets the bench line up an overflow in the same cycle as an acknowledge or a write, so those priority rules are checked directly.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;
   typedef enum logic {
      MODE_PRESCALED = 1'b0,
      MODE_RELOAD    = 1'b1
   } tmr_mode_e;
endpackage

// File: rtl/evtmr_sync.sv
module evtmr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic fall_o
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin_i};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign fall_o = last_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/evtmr_core.sv
module evtmr_core
   import evtmr_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int PRE_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  tmr_mode_e        mode_i,
   input  logic             lo_wr_i,
   input  logic [CNT_W-1:0] lo_wd_i,
   input  logic             hi_wr_i,
   input  logic [CNT_W-1:0] hi_wd_i,
   input  logic             flag_wr_i,
   input  logic             flag_wd_i,
   input  logic             ack_i,
   output logic [CNT_W-1:0] lo_o,
   output logic [CNT_W-1:0] hi_o,
   output logic             flag_o,
   output logic             ovf_o
);
   localparam logic [PRE_W-1:0] PRE_TOP = {PRE_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

   logic [CNT_W-1:0] lo_q, hi_q, lo_nx, hi_nx;
   logic             flag_q, ovf;

   always_comb begin
      lo_nx = lo_q;
      hi_nx = hi_q;
      ovf   = 1'b0;
      if (step_i) begin
         if (mode_i == MODE_RELOAD) begin
            if (lo_q == CNT_TOP) begin
               lo_nx = hi_q;
               ovf   = 1'b1;
            end else begin
               lo_nx = lo_q + 1'b1;
            end
         end else begin
            if (lo_q[PRE_W-1:0] == PRE_TOP) begin
               lo_nx[PRE_W-1:0] = '0;
               hi_nx            = hi_q + 1'b1;
               ovf              = (hi_q == CNT_TOP);
            end else begin
               lo_nx[PRE_W-1:0] = lo_q[PRE_W-1:0] + 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q   <= '0;
         hi_q   <= '0;
         flag_q <= 1'b0;
      end else begin
         lo_q <= lo_wr_i ? lo_wd_i : lo_nx;
         hi_q <= hi_wr_i ? hi_wd_i : hi_nx;
         if (flag_wr_i)  flag_q <= flag_wd_i;
         else if (ovf)   flag_q <= 1'b1;
         else if (ack_i) flag_q <= 1'b0;
      end
   end

   assign lo_o   = lo_q;
   assign hi_o   = hi_q;
   assign flag_o = flag_q;
   assign ovf_o  = ovf;

   a_r2_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MODE_PRESCALED && !lo_wr_i) |=> $stable(lo_o[CNT_W-1:PRE_W]));
   a_r3_flag_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && !flag_wr_i) |=> flag_o);
   a_r4_hi_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MODE_RELOAD && !hi_wr_i) |=> $stable(hi_o));
   a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !ovf_o && !flag_wr_i) |=> !flag_o);
   a_r8_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
      lo_wr_i |=> (lo_o == $past(lo_wd_i)));
   a_r8_flag_write: assert property (@(posedge clk) disable iff (!rst_n)
      flag_wr_i |=> (flag_o == $past(flag_wd_i)));
endmodule

// File: rtl/evtmr_toggle.sv
module evtmr_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic ovf_i,
   input  logic en_i,
   output logic wave_o
);
   logic wave_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             wave_q <= 1'b0;
      else if (ovf_i && en_i) wave_q <= ~wave_q;
   end

   assign wave_o = wave_q;

   a_r9_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_i && en_i) |=> (wave_o != $past(wave_o)));
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> $stable(wave_o));
endmodule

// File: rtl/evtmr_top.sv
module evtmr_top
   import evtmr_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int PRE_W       = 5,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_TOGGLE  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             gate_en,
   input  logic             gate_in,
   input  logic             evt_sel,
   input  logic             mode_sel,
   input  logic             evt_pin,
   input  logic             lo_wr,
   input  logic [CNT_W-1:0] lo_wdata,
   input  logic             hi_wr,
   input  logic [CNT_W-1:0] hi_wdata,
   input  logic             flag_wr,
   input  logic             flag_wdata,
   input  logic             int_ack,
   input  logic             tgl_en,
   output logic [CNT_W-1:0] cnt_lo,
   output logic [CNT_W-1:0] cnt_hi,
   output logic             ovf_flag,
   output logic             tgl_out
);
   if (PRE_W < 1 || PRE_W >= CNT_W) begin : g_bad_pre
      $error("PRE_W must lie between 1 and CNT_W-1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic evt_fall, allowed, step, ovf;

   evtmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (evt_pin),
      .fall_o (evt_fall)
   );

   assign allowed = run_en & (~gate_en | gate_in);
   assign step    = allowed & (evt_sel ? evt_fall : 1'b1);

   evtmr_core #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_i    (step),
      .mode_i    (tmr_mode_e'(mode_sel)),
      .lo_wr_i   (lo_wr),
      .lo_wd_i   (lo_wdata),
      .hi_wr_i   (hi_wr),
      .hi_wd_i   (hi_wdata),
      .flag_wr_i (flag_wr),
      .flag_wd_i (flag_wdata),
      .ack_i     (int_ack),
      .lo_o      (cnt_lo),
      .hi_o      (cnt_hi),
      .flag_o    (ovf_flag),
      .ovf_o     (ovf)
   );

   if (HAS_TOGGLE) begin : g_wave
      evtmr_toggle u_wave (
         .clk    (clk),
         .rst_n  (rst_n),
         .ovf_i  (ovf),
         .en_i   (tgl_en),
         .wave_o (tgl_out)
      );
   end else begin : g_no_wave
      assign tgl_out = 1'b0;
   end

   a_r6_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!(run_en && (!gate_en || gate_in)) && !lo_wr && !hi_wr)
      |=> ($stable(cnt_lo) && $stable(cnt_hi)));
   a_r7_no_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_sel && !evt_fall && !lo_wr && !hi_wr)
      |=> ($stable(cnt_lo) && $stable(cnt_hi)));
endmodule

// File: tb/tb_evtmr_top.sv
module tb_evtmr_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run_en = 0, gate_en = 0, gate_in = 0, evt_sel = 0, mode_sel = 0;
   logic       evt_pin = 0, lo_wr = 0, hi_wr = 0, flag_wr = 0, flag_wdata = 0;
   logic       int_ack = 0, tgl_en = 0;
   logic [7:0] lo_wdata = 0, hi_wdata = 0;
   logic [7:0] cnt_lo, cnt_hi;
   logic       ovf_flag, tgl_out;

   always #2 clk = ~clk;

   evtmr_top dut (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .gate_en(gate_en),
      .gate_in(gate_in), .evt_sel(evt_sel), .mode_sel(mode_sel),
      .evt_pin(evt_pin), .lo_wr(lo_wr), .lo_wdata(lo_wdata), .hi_wr(hi_wr),
      .hi_wdata(hi_wdata), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
      .int_ack(int_ack), .tgl_en(tgl_en), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
      .ovf_flag(ovf_flag), .tgl_out(tgl_out)
   );

   int    n_cmp = 0, n_bad = 0;
   bit    started = 0, done = 0;
   string cur_req = "R1";

   // behavioural reference model
   int m_lo, m_hi, m_flag, m_tgl, m_s1, m_s2, m_prev;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_lo = 0; m_hi = 0; m_flag = 0; m_tgl = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
      end else begin
         int nlo, nhi, ov, fall, go;
         fall   = (m_prev == 1 && m_s2 == 0) ? 1 : 0;
         m_prev = m_s2; m_s2 = m_s1; m_s1 = evt_pin;
         go  = (run_en && (!gate_en || gate_in) && (evt_sel ? fall : 1)) ? 1 : 0;
         ov  = 0; nlo = m_lo; nhi = m_hi;
         if (go) begin
            if (mode_sel) begin
               if (m_lo == 255) begin nlo = m_hi; ov = 1; end
               else nlo = m_lo + 1;
            end else if (m_lo % 32 == 31) begin
               nlo = m_lo - 31; nhi = (m_hi + 1) % 256; ov = (m_hi == 255);
            end else nlo = m_lo + 1;
         end
         if (flag_wr)      m_flag = flag_wdata;
         else if (ov)      m_flag = 1;
         else if (int_ack) m_flag = 0;
         if (lo_wr) nlo = lo_wdata;
         if (hi_wr) nhi = hi_wdata;
         if (ov && tgl_en) m_tgl = 1 - m_tgl;
         m_lo = nlo; m_hi = nhi;
      end
   end

   task automatic chk(string req, string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (started && !done) begin
         chk(cur_req, "cnt_lo",   cnt_lo,   m_lo);
         chk(cur_req, "cnt_hi",   cnt_hi,   m_hi);
         chk(cur_req, "ovf_flag", ovf_flag, m_flag);
         chk(cur_req, "tgl_out",  tgl_out,  m_tgl);
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic load(int lo, int hi);
      lo_wr = 1; lo_wdata = lo[7:0]; hi_wr = 1; hi_wdata = hi[7:0];
      cyc(1);
      lo_wr = 0; hi_wr = 0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      cyc(3);
      chk("R1", "reset lo", cnt_lo, 0);
      chk("R1", "reset hi", cnt_hi, 0);
      chk("R1", "reset flag", ovf_flag, 0);
      chk("R1", "reset wave", tgl_out, 0);
      rst_n = 1; started = 1;
      cyc(1);

      // R2: prescaled counting, upper low bits untouched
      cur_req = "R2";
      load('hE0, 0);
      run_en = 1; cyc(70); run_en = 0;
      chk("R2", "hi after 70", cnt_hi, 2);
      chk("R2", "lo after 70", cnt_lo, 'hE6);

      // R3 and R9: 13-bit wrap with waveform enabled
      cur_req = "R3";
      tgl_en = 1;
      load('h1D, 'hFF);
      run_en = 1; cyc(3); run_en = 0;
      chk("R3", "hi wrap", cnt_hi, 0);
      chk("R3", "lo wrap", cnt_lo, 0);
      chk("R3", "flag set", ovf_flag, 1);
      chk("R9", "wave flipped", tgl_out, 1);

      // R5: ack clears, concurrent overflow wins
      cur_req = "R5";
      int_ack = 1; cyc(1); int_ack = 0;
      chk("R5", "ack clear", ovf_flag, 0);
      load('h1F, 'hFF);
      run_en = 1; int_ack = 1; cyc(1); run_en = 0; int_ack = 0;
      chk("R5", "ovf beats ack", ovf_flag, 1);

      // R4: reload mode
      cur_req = "R4";
      flag_wr = 1; flag_wdata = 0; cyc(1); flag_wr = 0;
      mode_sel = 1;
      load('hFD, 'hF0);
      run_en = 1; cyc(5); run_en = 0;
      chk("R4", "lo reloaded", cnt_lo, 'hF2);
      chk("R4", "hi kept", cnt_hi, 'hF0);
      chk("R4", "flag set", ovf_flag, 1);
      run_en = 1; cyc(40); run_en = 0;

      // R6: gating
      cur_req = "R6";
      load(5, 'h80);
      run_en = 1; gate_en = 1; gate_in = 0; cyc(20);
      chk("R6", "gate low holds", cnt_lo, 5);
      gate_in = 1; cyc(3);
      chk("R6", "gate high counts", cnt_lo, 8);
      for (int i = 0; i < 12; i++) begin gate_in = i[0]; cyc(1 + i % 3); end
      run_en = 0; gate_in = 1; cyc(5);
      chk("R6", "run low holds", cnt_lo, m_lo);
      gate_en = 0;

      // R7: event counting through synchronizer
      cur_req = "R7";
      mode_sel = 0; evt_sel = 1; evt_pin = 1;
      load(0, 0);
      run_en = 1; cyc(4);
      chk("R7", "steady high no step", cnt_lo, 0);
      for (int i = 0; i < 5; i++) begin
         evt_pin = 0; cyc(2 + i % 2);
         evt_pin = 1; cyc(3);
      end
      cyc(4);
      chk("R7", "five falls", cnt_lo, 5);
      evt_pin = 0; cyc(20);
      chk("R7", "held low one step", cnt_lo, 6);
      evt_pin = 1; cyc(1); evt_pin = 0; cyc(2);
      chk("R7", "fall not yet counted", cnt_lo, 6);
      cyc(1);
      chk("R7", "fall counted third edge", cnt_lo, 7);
      evt_sel = 0; run_en = 0;

      // R8: writes override hardware
      cur_req = "R8";
      mode_sel = 1;
      load(10, 3);
      run_en = 1; lo_wr = 1; lo_wdata = 'h55; cyc(1); lo_wr = 0; run_en = 0;
      chk("R8", "lo write wins", cnt_lo, 'h55);
      load('hFF, 3);
      run_en = 1; flag_wr = 1; flag_wdata = 0; cyc(1);
      run_en = 0; flag_wr = 0;
      chk("R8", "flag write wins", ovf_flag, 0);
      chk("R8", "reloaded anyway", cnt_lo, 3);

      // R9: waveform disabled then enabled
      cur_req = "R9";
      tgl_en = 0;
      load('hFE, 'hFE);
      run_en = 1; cyc(10);
      chk("R9", "wave held", tgl_out, m_tgl);
      tgl_en = 1; cyc(11);
      run_en = 0; cyc(2);

      finish_run();
   end
endmodule